// File: doc/BRIEF.md
# Multi-channel color sequencer

This block is the digital controller of a three-input image sensor front end. Each sample clock it decides which color input (red, green or blue) feeds the converter. It presents the gain and offset codes that belong to that color to the analog stage. It also drives the converted 8-bit code onto the output bus, together with a color tag that has been delayed to match the converter latency. The analog sampling, the clamp and the converter lie outside the block. The converter result enters as a plain data input that is already delayed.

Four rotation schemes are available. The first keeps a fixed red input. The second alternates red and green every pixel. The third steps through all three colors every pixel. The fourth steps through all three colors once per scan line. A line-start strobe returns the pixel rotations to red and holds the bus in high impedance. A polarity bit complements the output code, so that inverted-signal sensors still read zero for a dark pixel. An output-disable bit keeps the bus released.

Top module: `color_sequencer`

## Requirements
- R1: While `rst_n` is low, `color_sel` is red, and `bus_oe`, `tag_out`, `gain_out`, `ofs_out` and `bus_out` are all zero. After reset, `bus_oe` stays low until the line-start strobe has been high and has then been sampled low (a strobe fall).
- R2: Colors are encoded red=00, green=01, blue=10. With `cfg_mode`=00, `color_sel` is red after every clock edge.
- R3: With `cfg_mode`=01, each edge that samples the strobe low toggles `color_sel` between red and green. If the old value is not red, the new value is red. Each edge that samples the strobe high sets red.
- R4: With `cfg_mode`=10, each edge that samples the strobe low steps `color_sel` red→green→blue→red. Each edge that samples the strobe high sets red.
- R5: With `cfg_mode`=11, `color_sel` changes only at an edge that samples a strobe fall, or at an edge that samples `mode_wr` high together with `cfg_mode`=11. That write sets red. The first strobe fall after reset or after such a write selects red. Every later fall steps red→green→blue→red.
- R6: `gain_out` and `ofs_out` change at the same edge as `color_sel`. They hold the gain and offset register values of the color that `color_sel` now shows.
- R7: In each cycle, `bus_out` holds the `adc_code` of the previous cycle. The code is bitwise complemented when `invert` was high in that cycle.
- R8: In each cycle, `bus_oe` is high exactly when, in the previous cycle, the strobe and `out_off` were both low and a strobe fall had been sampled at some point since reset.
- R9: In cycle m, `tag_out` equals the `color_sel` of cycle m−8 when `cfg_mode` is 00 or 11, and of cycle m−6 when `cfg_mode` is 01 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Line-start strobe |
| cfg_mode | input | 2 | Rotation scheme (00 fixed, 01 pair, 10 pixel trio, 11 line trio) |
| mode_wr | input | 1 | One-cycle pulse when the mode register is rewritten |
| invert | input | 1 | Complement the output code |
| out_off | input | 1 | Keep the output bus released |
| adc_code | input | 8 | Converter result |
| gain_red | input | 6 | Red gain register |
| gain_grn | input | 6 | Green gain register |
| gain_blu | input | 6 | Blue gain register |
| ofs_red | input | 8 | Red offset register |
| ofs_grn | input | 8 | Green offset register |
| ofs_blu | input | 8 | Blue offset register |
| color_sel | output | 2 | Selected color input |
| gain_out | output | 6 | Gain code of the selected color |
| ofs_out | output | 8 | Offset code of the selected color |
| tag_out | output | 2 | Color of the sample now on the bus |
| bus_out | output | 8 | Output data code |
| bus_oe | output | 1 | Output bus drive enable (low means high impedance) |

## Verification
The bench builds the block with its default parameters: latencies of 8 and 6 cycles and code widths of 6 and 8 bits. Because the two latencies differ, a mixed color history tells the two tag taps apart, and switching between the fixed and pixel schemes shows the tap following `cfg_mode`. The default widths let the vector table cover full-scale and zero codes under both polarities. With three distinct gain and offset values per color, a wrong select is caught in every cycle.

// File: rtl/csq_pkg.sv
`timescale 1ns/1ps
package csq_pkg;

    typedef enum logic [1:0] {
        COL_RED = 2'd0,
        COL_GRN = 2'd1,
        COL_BLU = 2'd2
    } color_e;

    typedef enum logic [1:0] {
        MODE_FIXED   = 2'd0,
        MODE_PAIR    = 2'd1,
        MODE_TRIPIX  = 2'd2,
        MODE_TRILINE = 2'd3
    } mode_e;

    function automatic color_e step_pair(color_e c);
        return (c == COL_RED) ? COL_GRN : COL_RED;
    endfunction

    function automatic color_e step_trio(color_e c);
        case (c)
            COL_RED: return COL_GRN;
            COL_GRN: return COL_BLU;
            default: return COL_RED;
        endcase
    endfunction

    function automatic logic long_latency(mode_e m);
        return (m == MODE_FIXED) || (m == MODE_TRILINE);
    endfunction

endpackage

// File: rtl/csq_pointer.sv
`timescale 1ns/1ps
module csq_pointer
    import csq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_start,
    input  logic [1:0] cfg_mode,
    input  logic       mode_wr,
    output color_e     color_o,
    output color_e     color_nxt_o,
    output logic       line_fall_o
);

    typedef struct packed {
        color_e col;
        logic   arm;
        logic   line;
    } ptr_s;

    ptr_s   st_d, st_q;
    mode_e  mode;
    logic   fall;

    assign mode = mode_e'(cfg_mode);
    assign fall = st_q.line & ~line_start;

    always_comb begin
        st_d      = st_q;
        st_d.line = line_start;
        if (mode_wr && mode == MODE_TRILINE) begin
            st_d.col = COL_RED;
            st_d.arm = 1'b1;
        end else begin
            case (mode)
                MODE_FIXED:  st_d.col = COL_RED;
                MODE_PAIR:   st_d.col = line_start ? COL_RED : step_pair(st_q.col);
                MODE_TRIPIX: st_d.col = line_start ? COL_RED : step_trio(st_q.col);
                default: begin
                    if (fall) begin
                        st_d.col = st_q.arm ? COL_RED : step_trio(st_q.col);
                        st_d.arm = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{col: COL_RED, arm: 1'b1, line: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign color_o     = st_q.col;
    assign color_nxt_o = st_d.col;
    assign line_fall_o = fall;

    assert_legal_color_R2: assert property (@(posedge clk) disable iff (!rst_n)
        color_o != color_e'(2'b11));

    assert_fixed_red_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode == 2'b00 |=> color_o == COL_RED);

    assert_pair_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b01 && !line_start && color_o == COL_RED) |=> color_o == COL_GRN);

    assert_strobe_red_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && (cfg_mode == 2'b01 || cfg_mode == 2'b10)) |=> color_o == COL_RED);

    assert_trio_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b10 && !line_start && color_o == COL_GRN) |=> color_o == COL_BLU);

    assert_line_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b11 && !mode_wr && !fall) |=> $stable(color_o));

    assert_rewrite_red_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b11 && mode_wr) |=> color_o == COL_RED);

endmodule

// File: rtl/csq_code_sel.sv
`timescale 1ns/1ps
module csq_code_sel
    import csq_pkg::*;
#(
    parameter int GAIN_W = 6,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  color_e            color_nxt_i,
    input  logic [GAIN_W-1:0] gain_red,
    input  logic [GAIN_W-1:0] gain_grn,
    input  logic [GAIN_W-1:0] gain_blu,
    input  logic [OFS_W-1:0]  ofs_red,
    input  logic [OFS_W-1:0]  ofs_grn,
    input  logic [OFS_W-1:0]  ofs_blu,
    output logic [GAIN_W-1:0] gain_o,
    output logic [OFS_W-1:0]  ofs_o
);

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic [OFS_W-1:0]  ofs;
    } code_s;

    code_s cd_d, cd_q;

    always_comb begin
        case (color_nxt_i)
            COL_GRN: begin
                cd_d.gain = gain_grn;
                cd_d.ofs  = ofs_grn;
            end
            COL_BLU: begin
                cd_d.gain = gain_blu;
                cd_d.ofs  = ofs_blu;
            end
            default: begin
                cd_d.gain = gain_red;
                cd_d.ofs  = ofs_red;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cd_q <= '0;
        end else begin
            cd_q <= cd_d;
        end
    end

    assign gain_o = cd_q.gain;
    assign ofs_o  = cd_q.ofs;

endmodule

// File: rtl/csq_tag_delay.sv
`timescale 1ns/1ps
module csq_tag_delay
    import csq_pkg::*;
#(
    parameter int LAT_LONG  = 8,
    parameter int LAT_SHORT = 6
) (
    input  logic   clk,
    input  logic   rst_n,
    input  color_e color_i,
    input  logic   long_i,
    output color_e tag_o
);

    localparam int DEPTH = (LAT_LONG > LAT_SHORT) ? LAT_LONG : LAT_SHORT;
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][1:0] hist;
    } tag_s;

    tag_s           tg_d, tg_q;
    logic [IW-1:0]  tap;

    always_comb begin
        tg_d.hist[0] = color_i;
        for (int i = 1; i < DEPTH; i++) begin
            tg_d.hist[i] = tg_q.hist[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tg_q <= '0;
        end else begin
            tg_q <= tg_d;
        end
    end

    assign tap   = long_i ? IW'(LAT_LONG - 1) : IW'(LAT_SHORT - 1);
    assign tag_o = color_e'(tg_q.hist[tap]);

endmodule

// File: rtl/color_sequencer.sv
`timescale 1ns/1ps
module color_sequencer
    import csq_pkg::*;
#(
    parameter int GAIN_W    = 6,
    parameter int OFS_W     = 8,
    parameter int DATA_W    = 8,
    parameter int LAT_LONG  = 8,
    parameter int LAT_SHORT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [1:0]        cfg_mode,
    input  logic              mode_wr,
    input  logic              invert,
    input  logic              out_off,
    input  logic [DATA_W-1:0] adc_code,
    input  logic [GAIN_W-1:0] gain_red,
    input  logic [GAIN_W-1:0] gain_grn,
    input  logic [GAIN_W-1:0] gain_blu,
    input  logic [OFS_W-1:0]  ofs_red,
    input  logic [OFS_W-1:0]  ofs_grn,
    input  logic [OFS_W-1:0]  ofs_blu,
    output logic [1:0]        color_sel,
    output logic [GAIN_W-1:0] gain_out,
    output logic [OFS_W-1:0]  ofs_out,
    output logic [1:0]        tag_out,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);

    typedef struct packed {
        logic              started;
        logic              oe;
        logic [DATA_W-1:0] data;
    } bus_s;

    color_e col, col_nxt, tag;
    logic   line_fall;
    bus_s   bs_d, bs_q;

    csq_pointer u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start  (line_start),
        .cfg_mode    (cfg_mode),
        .mode_wr     (mode_wr),
        .color_o     (col),
        .color_nxt_o (col_nxt),
        .line_fall_o (line_fall)
    );

    csq_code_sel #(
        .GAIN_W (GAIN_W),
        .OFS_W  (OFS_W)
    ) u_code (
        .clk         (clk),
        .rst_n       (rst_n),
        .color_nxt_i (col_nxt),
        .gain_red    (gain_red),
        .gain_grn    (gain_grn),
        .gain_blu    (gain_blu),
        .ofs_red     (ofs_red),
        .ofs_grn     (ofs_grn),
        .ofs_blu     (ofs_blu),
        .gain_o      (gain_out),
        .ofs_o       (ofs_out)
    );

    csq_tag_delay #(
        .LAT_LONG  (LAT_LONG),
        .LAT_SHORT (LAT_SHORT)
    ) u_tag (
        .clk     (clk),
        .rst_n   (rst_n),
        .color_i (col),
        .long_i  (long_latency(mode_e'(cfg_mode))),
        .tag_o   (tag)
    );

    always_comb begin
        bs_d.started = bs_q.started | line_fall;
        bs_d.oe      = bs_d.started & ~line_start & ~out_off;
        bs_d.data    = invert ? ~adc_code : adc_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bs_q <= '0;
        end else begin
            bs_q <= bs_d;
        end
    end

    assign color_sel = col;
    assign tag_out   = tag;
    assign bus_out   = bs_q.data;
    assign bus_oe    = bs_q.oe;

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start || out_off) |=> !bus_oe);

    assert_no_drive_before_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!bs_q.started && !line_fall) |=> !bus_oe);

    assert_green_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (color_sel == COL_GRN) |-> (gain_out == $past(gain_grn) && ofs_out == $past(ofs_grn)));

    assert_blue_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (color_sel == COL_BLU) |-> (gain_out == $past(gain_blu) && ofs_out == $past(ofs_blu)));

    assert_dark_inverted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (invert && adc_code == '0) |=> bus_out == '1);

    assert_tag_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tag_out != 2'b11);

endmodule

// File: tb/sim_color_sequencer.sv
`timescale 1ns/1ps
module sim_color_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic       mode_wr = 1'b0;
    logic       invert = 1'b0;
    logic       out_off = 1'b0;
    logic [7:0] adc_code = 8'h00;
    logic [5:0] gain_red = 6'd5,  gain_grn = 6'd20,  gain_blu = 6'd45;
    logic [7:0] ofs_red = 8'h11,  ofs_grn = 8'h82,   ofs_blu = 8'hF3;
    logic [1:0] color_sel, tag_out;
    logic [5:0] gain_out;
    logic [7:0] ofs_out, bus_out;
    logic       bus_oe;

    always #5 clk = ~clk;

    color_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .cfg_mode(cfg_mode),
        .mode_wr(mode_wr), .invert(invert), .out_off(out_off), .adc_code(adc_code),
        .gain_red(gain_red), .gain_grn(gain_grn), .gain_blu(gain_blu),
        .ofs_red(ofs_red), .ofs_grn(ofs_grn), .ofs_blu(ofs_blu),
        .color_sel(color_sel), .gain_out(gain_out), .ofs_out(ofs_out),
        .tag_out(tag_out), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // expected-behaviour model, built from the requirement text
    logic [1:0] m_col = 2'd0;
    logic       m_arm = 1'b1;
    logic       m_started = 1'b0;
    logic       m_oe = 1'b0;
    logic       m_prev = 1'b0;
    logic [7:0] m_bus = 8'h00;
    logic [1:0] m_hist [0:7] = '{default: 2'd0};

    // {invert, adc_code, expected bus code}
    localparam logic [16:0] VEC [0:7] = '{
        {1'b0, 8'h00, 8'h00}, {1'b1, 8'h00, 8'hFF},
        {1'b0, 8'h5A, 8'h5A}, {1'b1, 8'h5A, 8'hA5},
        {1'b0, 8'hFF, 8'hFF}, {1'b1, 8'hFF, 8'h00},
        {1'b1, 8'h3C, 8'hC3}, {1'b0, 8'h81, 8'h81}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] exp_gain(logic [1:0] c);
        return (c == 2'd1) ? gain_grn : (c == 2'd2) ? gain_blu : gain_red;
    endfunction

    function automatic logic [7:0] exp_ofs(logic [1:0] c);
        return (c == 2'd1) ? ofs_grn : (c == 2'd2) ? ofs_blu : ofs_red;
    endfunction

    task automatic check_all(input string creq);
        int lat;
        lat = (cfg_mode == 2'b00 || cfg_mode == 2'b11) ? 8 : 6;
        chk(color_sel == m_col, creq, "color_sel", color_sel, m_col);
        chk(gain_out == exp_gain(m_col), "R6", "gain_out", gain_out, exp_gain(m_col));
        chk(ofs_out == exp_ofs(m_col), "R6", "ofs_out", ofs_out, exp_ofs(m_col));
        chk(tag_out == m_hist[lat-1], "R9", "tag_out", tag_out, m_hist[lat-1]);
        chk(bus_oe == m_oe, "R8", "bus_oe", bus_oe, m_oe);
        chk(bus_out == m_bus, "R7", "bus_out", bus_out, m_bus);
    endtask

    // called just after a falling edge; applies inputs for one cycle
    task automatic step(input logic ls, input logic [1:0] md, input logic wr,
                        input logic [7:0] adc);
        logic fall;
        line_start = ls; cfg_mode = md; mode_wr = wr; adc_code = adc;
        fall = m_prev & ~ls;
        for (int i = 7; i > 0; i--) m_hist[i] = m_hist[i-1];
        m_hist[0] = m_col;
        if (wr && md == 2'b11) begin
            m_col = 2'd0; m_arm = 1'b1;
        end else if (md == 2'b00) begin
            m_col = 2'd0;
        end else if (md == 2'b01) begin
            m_col = ls ? 2'd0 : ((m_col == 2'd0) ? 2'd1 : 2'd0);
        end else if (md == 2'b10) begin
            m_col = ls ? 2'd0 : ((m_col == 2'd0) ? 2'd1 : (m_col == 2'd1) ? 2'd2 : 2'd0);
        end else if (fall) begin
            if (m_arm) m_col = 2'd0;
            else m_col = (m_col == 2'd0) ? 2'd1 : (m_col == 2'd1) ? 2'd2 : 2'd0;
            m_arm = 1'b0;
        end
        m_started = m_started | fall;
        m_oe  = m_started & ~ls & ~out_off;
        m_bus = invert ? ~adc : adc;
        m_prev = ls;
        @(posedge clk);
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic line(input logic [1:0] md, input int high, input int low, input string creq);
        for (int i = 0; i < high; i++) begin step(1'b1, md, 1'b0, 8'(i + 3)); check_all(creq); end
        for (int i = 0; i < low; i++)  begin step(1'b0, md, 1'b0, 8'(i * 7)); check_all(creq); end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(color_sel == 2'd0, "R1", "reset color_sel", color_sel, 0);
        chk(bus_oe == 1'b0, "R1", "reset bus_oe", bus_oe, 0);
        chk(tag_out == 2'd0, "R1", "reset tag_out", tag_out, 0);
        chk(gain_out == 6'd0 && ofs_out == 8'd0, "R1", "reset codes", {gain_out, ofs_out}, 0);
        chk(bus_out == 8'd0, "R1", "reset bus_out", bus_out, 0);
        rst_n = 1'b1;

        // R1/R8: no drive before the first strobe fall
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 2'b00, 1'b0, 8'h40);
            chk(bus_oe == 1'b0, "R1", "bus_oe before first line", bus_oe, 0);
            check_all("R2");
        end
        line(2'b00, 2, 3, "R2");

        // R7: data path vectors
        for (int i = 0; i < 8; i++) begin
            invert = VEC[i][16];
            step(1'b0, 2'b00, 1'b0, VEC[i][15:8]);
            chk(bus_out == VEC[i][7:0], "R7", "vector bus_out", bus_out, VEC[i][7:0]);
            check_all("R2");
        end
        invert = 1'b0;

        // R3: red/green alternation, strobe forces red
        line(2'b01, 1, 7, "R3");
        line(2'b01, 2, 3, "R3");

        // R4: three-color pixel rotation
        line(2'b10, 1, 8, "R4");
        line(2'b10, 1, 2, "R4");

        // R5: line-by-line rotation with register rewrites
        step(1'b0, 2'b11, 1'b1, 8'h10);
        check_all("R5");
        chk(color_sel == 2'd0, "R5", "red after rewrite", color_sel, 0);
        for (int n = 0; n < 4; n++) line(2'b11, 2, 4, "R5");
        step(1'b0, 2'b11, 1'b1, 8'h20);
        check_all("R5");
        line(2'b11, 1, 3, "R5");
        chk(color_sel == 2'd0, "R5", "first line after rewrite is red", color_sel, 0);
        line(2'b11, 1, 3, "R5");
        chk(color_sel == 2'd1, "R5", "second line green", color_sel, 1);

        // R8: output disable overrides
        out_off = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 2'b11, 1'b0, 8'h77);
            chk(bus_oe == 1'b0, "R8", "bus_oe with out_off", bus_oe, 0);
            check_all("R5");
        end
        out_off = 1'b0;

        // R9: mixed history then tap switch between latencies
        line(2'b10, 1, 9, "R4");
        line(2'b00, 0, 4, "R2");
        line(2'b01, 1, 5, "R3");
        line(2'b00, 0, 9, "R9");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule